// File: doc/BRIEF.md
# 64b/66b Receive Block Decoder

This block sits in a 10GBASE-R receive path after descrambling and block alignment. Each cycle it takes one 66-bit block, split into a 64-bit payload and a 2-bit sync header. It rebuilds the matching XGMII word: eight 8-bit lanes plus one control bit per lane. A data-header block passes straight through. A control-header block is read through its 8-bit block-type field in payload bits [7:0]. That field selects how the rest of the payload is split into lanes: 7-bit control codes, data bytes, Start and Terminate characters, or 4-bit ordered-set codes. Each 7-bit code is widened back to its 8-bit XGMII character.

A block that cannot be decoded still produces a word. Each lane that cannot be rebuilt becomes the Error character with its control bit set. A one-cycle error flag goes out with that word. All outputs are registered, so the result appears one clock after the block is presented.

Top module: `blk66_rx_decoder`

## Requirements
- R1: Sync header 2'b10 gives a data block: the output data equals the payload and the control mask is 8'h00.
- R2: Sync header 2'b01 with block type 8'h1E gives eight control lanes. Lane i is taken from the 7-bit code at payload bits [8+7i +: 7]. Codes map 7'h00→8'h07 (idle), 7'h06→8'h06 (low-power idle), 7'h1E→8'hFE (error), 7'h2D→8'h1C, 7'h33→8'h3C, 7'h4B→8'h7C, 7'h55→8'hBC, 7'h66→8'hDC, 7'h78→8'hF7.
- R3: Any other 7-bit code yields 8'hFE in that lane with its control bit set. Only the lanes holding such a code are affected.
- R4: Block type 8'h78 gives Start (8'hFB, control) in lane 0, and payload bytes 1..7 as data in lanes 1..7.
- R5: Block type 8'h33 gives code lanes 0..3 from bits [8+7i +: 7], Start in lane 4, and payload bytes 5..7 as data in lanes 5..7. Mask 8'h1F.
- R6: Ordered-set blocks: 8'h4B has an ordered set in lane 0, with its 4-bit code at bits [35:32], data lanes 1..3 and code lanes 4..7. 8'h2D has code lanes 0..3, an ordered set in lane 4 with its code at bits [39:36], and data lanes 5..7. 8'h55 has ordered sets in lanes 0 and 4, with data lanes 1..3 and 5..7. 8'h66 has an ordered set in lane 0 and Start in lane 4. Ordered-set code 4'h0 gives 8'h9C and 4'hF gives 8'h5C; any other code gives 8'hFE with an error. Data lanes take payload byte i.
- R7: Block types 8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF put Terminate (8'hFD, control) in lane 0..7 respectively. Lanes below it carry payload byte i+1 as data. Lanes above it decode the code at bits [8+7i +: 7].
- R8: Sync header 2'b00 or 2'b11 gives all lanes 8'hFE, mask 8'hFF, and the error flag.
- R9: A control block with any block type not listed above gives all lanes 8'hFE, mask 8'hFF, and the error flag.
- R10: Outputs change only on the clock edge that follows the block being presented (one register stage).
- R11: Synchronous reset drives data 64'h0707070707070707, mask 8'hFF, and clears the error flag.
- R12: The error flag is high exactly when at least one lane was replaced by an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_payload | input | 64 | Descrambled block payload |
| rx_sync | input | 2 | Block sync header |
| xg_data | output | 64 | Rebuilt XGMII lanes, lane 0 in bits [7:0] |
| xg_ctrl | output | 8 | Per-lane control mask |
| decode_err | output | 1 | Error replacement happened in this word |

## Verification
The assertions run on every cycle. They check that a data header passes the payload through with a clear mask and no error. They check that a bad header fills the word with error characters. They check the reset word, and that an error flag always comes with at least one control lane. Only the bench scenarios can show the lane layouts of each block type: the code widening, ordered-set lanes, start positions and all eight terminate positions. The bench round-trips XGMII words through its own encoder and compares the decoded result. It also covers single-lane error replacement for bad codes inside otherwise valid blocks.

// File: rtl/blkdec_pkg.sv
package blkdec_pkg;

   localparam logic [7:0] CH_IDLE  = 8'h07;
   localparam logic [7:0] CH_LPI   = 8'h06;
   localparam logic [7:0] CH_START = 8'hFB;
   localparam logic [7:0] CH_TERM  = 8'hFD;
   localparam logic [7:0] CH_ERROR = 8'hFE;
   localparam logic [7:0] CH_OSEQ  = 8'h9C;
   localparam logic [7:0] CH_OSIG  = 8'h5C;

   localparam logic [1:0] HDR_DATA = 2'b10;
   localparam logic [1:0] HDR_CTRL = 2'b01;

   localparam logic [7:0] BT_ALLCTL = 8'h1E;
   localparam logic [7:0] BT_S0     = 8'h78;
   localparam logic [7:0] BT_S4     = 8'h33;
   localparam logic [7:0] BT_OS4    = 8'h2D;
   localparam logic [7:0] BT_OS0    = 8'h4B;
   localparam logic [7:0] BT_OS04   = 8'h55;
   localparam logic [7:0] BT_OS0S4  = 8'h66;

   typedef enum logic [2:0] {
      SRC_CODE   = 3'd0,
      SRC_DATA   = 3'd1,
      SRC_DSHIFT = 3'd2,
      SRC_START  = 3'd3,
      SRC_TERM   = 3'd4,
      SRC_OSET   = 3'd5,
      SRC_ERR    = 3'd6
   } lane_src_e;

   // {valid, character}
   function automatic logic [8:0] widen_code(input logic [6:0] c);
      case (c)
         7'h00:   return {1'b1, CH_IDLE};
         7'h06:   return {1'b1, CH_LPI};
         7'h1E:   return {1'b1, CH_ERROR};
         7'h2D:   return {1'b1, 8'h1C};
         7'h33:   return {1'b1, 8'h3C};
         7'h4B:   return {1'b1, 8'h7C};
         7'h55:   return {1'b1, 8'hBC};
         7'h66:   return {1'b1, 8'hDC};
         7'h78:   return {1'b1, 8'hF7};
         default: return {1'b0, CH_ERROR};
      endcase
   endfunction

   // {valid, terminate lane}
   function automatic logic [3:0] term_position(input logic [7:0] bt);
      case (bt)
         8'h87:   return 4'b1_000;
         8'h99:   return 4'b1_001;
         8'hAA:   return 4'b1_010;
         8'hB4:   return 4'b1_011;
         8'hCC:   return 4'b1_100;
         8'hD2:   return 4'b1_101;
         8'hE1:   return 4'b1_110;
         8'hFF:   return 4'b1_111;
         default: return 4'b0_000;
      endcase
   endfunction

endpackage

// File: rtl/blkdec_code_map.sv
module blkdec_code_map
   import blkdec_pkg::*;
#(
   parameter int LANES    = 8,
   parameter int BYTE_W   = 8,
   parameter int CODE_W   = 7,
   parameter int CODE_LSB = 8,
   localparam int DATA_W  = LANES * BYTE_W
) (
   input  logic [DATA_W-1:0] payload,
   output logic [DATA_W-1:0] code_chars,
   output logic [LANES-1:0]  code_bad
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [8:0] wide;
      assign wide = widen_code(payload[CODE_LSB + CODE_W*i +: CODE_W]);
      assign code_chars[BYTE_W*i +: BYTE_W] = wide[7:0];
      assign code_bad[i] = ~wide[8];
   end

endmodule

// File: rtl/blkdec_type_decode.sv
module blkdec_type_decode
   import blkdec_pkg::*;
#(
   parameter int LANES = 8,
   localparam int HALF = LANES / 2
) (
   input  logic [1:0]             sync_hdr,
   input  logic [7:0]             block_type,
   output logic [LANES-1:0][2:0]  lane_src
);

   logic [3:0] term_info;
   assign term_info = term_position(block_type);

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         lane_src_e s;
         s = SRC_ERR;
         if (sync_hdr == HDR_DATA) begin
            s = SRC_DATA;
         end else if (sync_hdr == HDR_CTRL) begin
            case (block_type)
               BT_ALLCTL: s = SRC_CODE;
               BT_S0:     s = (i == 0) ? SRC_START : SRC_DATA;
               BT_S4:     s = (i < HALF) ? SRC_CODE :
                              (i == HALF) ? SRC_START : SRC_DATA;
               BT_OS4:    s = (i < HALF) ? SRC_CODE :
                              (i == HALF) ? SRC_OSET : SRC_DATA;
               BT_OS0:    s = (i == 0) ? SRC_OSET :
                              (i < HALF) ? SRC_DATA : SRC_CODE;
               BT_OS04:   s = (i == 0 || i == HALF) ? SRC_OSET : SRC_DATA;
               BT_OS0S4:  s = (i == 0) ? SRC_OSET :
                              (i == HALF) ? SRC_START : SRC_DATA;
               default: begin
                  if (term_info[3]) begin
                     if (i < int'(term_info[2:0]))       s = SRC_DSHIFT;
                     else if (i == int'(term_info[2:0])) s = SRC_TERM;
                     else                                s = SRC_CODE;
                  end else begin
                     s = SRC_ERR;
                  end
               end
            endcase
         end
         lane_src[i] = s;
      end
   end

endmodule

// File: rtl/blkdec_lane_mux.sv
module blkdec_lane_mux
   import blkdec_pkg::*;
#(
   parameter int LANES    = 8,
   parameter int BYTE_W   = 8,
   parameter int OCODE_W  = 4,
   localparam int DATA_W  = LANES * BYTE_W,
   localparam int HALF    = LANES / 2,
   localparam int OS0_LSB = HALF * BYTE_W,
   localparam int OS4_LSB = OS0_LSB + OCODE_W
) (
   input  logic [DATA_W-1:0]      payload,
   input  logic [LANES-1:0][2:0]  lane_src,
   input  logic [DATA_W-1:0]      code_chars,
   input  logic [LANES-1:0]       code_bad,
   output logic [DATA_W-1:0]      word_next,
   output logic [LANES-1:0]       ctrl_next,
   output logic                   err_next
);

   logic [LANES-1:0] lane_err;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int OLSB = (i < HALF) ? OS0_LSB : OS4_LSB;
      logic [BYTE_W-1:0]  shifted;
      logic [OCODE_W-1:0] ocode;

      if (i < LANES - 1) begin : g_shift
         assign shifted = payload[BYTE_W*(i+1) +: BYTE_W];
      end else begin : g_noshift
         assign shifted = CH_ERROR;
      end

      assign ocode = payload[OLSB +: OCODE_W];

      always_comb begin
         word_next[BYTE_W*i +: BYTE_W] = CH_ERROR;
         ctrl_next[i] = 1'b1;
         lane_err[i]  = 1'b0;
         case (lane_src_e'(lane_src[i]))
            SRC_CODE: begin
               word_next[BYTE_W*i +: BYTE_W] = code_chars[BYTE_W*i +: BYTE_W];
               lane_err[i] = code_bad[i];
            end
            SRC_DATA: begin
               word_next[BYTE_W*i +: BYTE_W] = payload[BYTE_W*i +: BYTE_W];
               ctrl_next[i] = 1'b0;
            end
            SRC_DSHIFT: begin
               word_next[BYTE_W*i +: BYTE_W] = shifted;
               ctrl_next[i] = 1'b0;
            end
            SRC_START: word_next[BYTE_W*i +: BYTE_W] = CH_START;
            SRC_TERM:  word_next[BYTE_W*i +: BYTE_W] = CH_TERM;
            SRC_OSET: begin
               if (ocode == '0)
                  word_next[BYTE_W*i +: BYTE_W] = CH_OSEQ;
               else if (ocode == '1)
                  word_next[BYTE_W*i +: BYTE_W] = CH_OSIG;
               else
                  lane_err[i] = 1'b1;
            end
            default: lane_err[i] = 1'b1;
         endcase
      end
   end

   assign err_next = |lane_err;

   // R3: a failed lane is always a control lane carrying the error character
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         assert_lane_err_char_R3: assert (!lane_err[i] ||
            (ctrl_next[i] && word_next[BYTE_W*i +: BYTE_W] == CH_ERROR))
            else $error("lane error without error character");
      end
   end

endmodule

// File: rtl/blk66_rx_decoder.sv
module blk66_rx_decoder
   import blkdec_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int BYTE_W  = 8,
   parameter int CODE_W  = 7,
   parameter int OCODE_W = 4,
   parameter int HDR_W   = 2,
   localparam int DATA_W = LANES * BYTE_W,
   localparam int BT_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [63:0]       rx_payload,
   input  logic [1:0]        rx_sync,
   output logic [63:0]       xg_data,
   output logic [7:0]        xg_ctrl,
   output logic              decode_err
);

   if (LANES != 8 || BYTE_W != 8 || DATA_W != 64) begin : g_bad_width
      $error("decoder needs eight 8-bit lanes");
   end
   if (CODE_W != 7 || OCODE_W != 4 || HDR_W != 2) begin : g_bad_field
      $error("decoder field widths are fixed by the line code");
   end
   if (BT_W + LANES * CODE_W != DATA_W) begin : g_bad_pack
      $error("control codes must fill the payload above the type field");
   end

   localparam logic [DATA_W-1:0] IDLE_WORD = {LANES{CH_IDLE}};
   localparam logic [DATA_W-1:0] ERR_WORD  = {LANES{CH_ERROR}};

   logic [DATA_W-1:0]     code_chars;
   logic [LANES-1:0]      code_bad;
   logic [LANES-1:0][2:0] lane_src;
   logic [DATA_W-1:0]     word_next;
   logic [LANES-1:0]      ctrl_next;
   logic                  err_next;

   blkdec_code_map #(
      .LANES(LANES), .BYTE_W(BYTE_W), .CODE_W(CODE_W), .CODE_LSB(BT_W)
   ) code_map_i (
      .payload(rx_payload), .code_chars(code_chars), .code_bad(code_bad)
   );

   blkdec_type_decode #(.LANES(LANES)) type_dec_i (
      .sync_hdr(rx_sync), .block_type(rx_payload[BT_W-1:0]), .lane_src(lane_src)
   );

   blkdec_lane_mux #(
      .LANES(LANES), .BYTE_W(BYTE_W), .OCODE_W(OCODE_W)
   ) lane_mux_i (
      .payload(rx_payload), .lane_src(lane_src), .code_chars(code_chars),
      .code_bad(code_bad), .word_next(word_next), .ctrl_next(ctrl_next),
      .err_next(err_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         xg_data    <= IDLE_WORD;
         xg_ctrl    <= '1;
         decode_err <= 1'b0;
      end else begin
         xg_data    <= word_next;
         xg_ctrl    <= ctrl_next;
         decode_err <= err_next;
      end
   end

   assert_data_pass_R1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rx_sync) == HDR_DATA) |->
         (xg_ctrl == '0 && xg_data == $past(rx_payload) && !decode_err))
      else $error("data block not passed through");

   assert_bad_hdr_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(rx_sync) == 2'b00 || $past(rx_sync) == 2'b11)) |->
         (xg_ctrl == '1 && xg_data == ERR_WORD && decode_err))
      else $error("bad header not replaced by errors");

   assert_reset_word_R11: assert property (@(posedge clk)
      $past(rst) |-> (xg_data == IDLE_WORD && xg_ctrl == '1 && !decode_err))
      else $error("reset word wrong");

   assert_err_has_ctrl_R12: assert property (@(posedge clk) disable iff (rst)
      decode_err |-> (xg_ctrl != '0))
      else $error("error flag with no control lane");

endmodule

// File: tb/blk66_rx_decoder_tb.sv
module blk66_rx_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] rx_payload = '0;
   logic [1:0]  rx_sync = 2'b10;
   logic [63:0] xg_data;
   logic [7:0]  xg_ctrl;
   logic        decode_err;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   blk66_rx_decoder dut_i (
      .clk(clk), .rst(rst), .rx_payload(rx_payload), .rx_sync(rx_sync),
      .xg_data(xg_data), .xg_ctrl(xg_ctrl), .decode_err(decode_err)
   );

   // {ctrl mask, data}
   localparam int NVEC = 18;
   localparam logic [71:0] VECS [NVEC] = '{
      {8'hFF, 64'h0707070707070707},
      {8'h00, 64'h0123456789ABCDEF},
      {8'h01, 64'hD5555555555555FB},
      {8'h1F, 64'h555555FB07070707},
      {8'hFF, 64'h07070707070707FD},
      {8'hFE, 64'h070707070707FD10},
      {8'hFC, 64'h0707070707FD1110},
      {8'hF8, 64'h07070707FD121110},
      {8'hF0, 64'h070707FD13121110},
      {8'hE0, 64'h0707FD1413121110},
      {8'hC0, 64'h07FD151413121110},
      {8'h80, 64'hFD16151413121110},
      {8'hFF, 64'h06FEF7DCBC7C3C1C},
      {8'hF1, 64'h070707070302019C},
      {8'h1F, 64'hA3A2A15C07070707},
      {8'h11, 64'hB7B6B55CB3B2B19C},
      {8'h11, 64'hC7C6C5FBC3C2C15C},
      {8'hFF, 64'h0606060607070707}
   };

   function automatic logic [6:0] narrow(input logic [7:0] ch);
      case (ch)
         8'h07: return 7'h00;  8'h06: return 7'h06;  8'hFE: return 7'h1E;
         8'h1C: return 7'h2D;  8'h3C: return 7'h33;  8'h7C: return 7'h4B;
         8'hBC: return 7'h55;  8'hDC: return 7'h66;  8'hF7: return 7'h78;
         default: return 7'h1E;
      endcase
   endfunction

   function automatic logic [3:0] onib(input logic [7:0] ch);
      return (ch == 8'h5C) ? 4'hF : 4'h0;
   endfunction

   function automatic logic [7:0] lane(input logic [63:0] d, input int i);
      return d[8*i +: 8];
   endfunction

   function automatic bit is_os(input logic [7:0] ch);
      return ch == 8'h9C || ch == 8'h5C;
   endfunction

   // tb-side encoder: returns {sync, payload}
   function automatic logic [65:0] encode(input logic [63:0] d, input logic [7:0] c);
      logic [63:0] p;
      logic [7:0] tcodes [8];
      int t;
      tcodes = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
      p = '0;
      if (c == 8'h00) return {2'b10, d};
      t = 0;
      while (t < 7 && !c[t]) t++;
      if (c == 8'h01 && lane(d, 0) == 8'hFB) begin
         p = {d[63:8], 8'h78};
      end else if (c == 8'h11 && is_os(lane(d, 0)) && lane(d, 4) == 8'hFB) begin
         p = {d[63:40], 4'h0, onib(lane(d, 0)), d[31:8], 8'h66};
      end else if (c == 8'h11 && is_os(lane(d, 0)) && is_os(lane(d, 4))) begin
         p = {d[63:40], onib(lane(d, 4)), onib(lane(d, 0)), d[31:8], 8'h55};
      end else if (c == 8'hF1 && is_os(lane(d, 0))) begin
         p[7:0] = 8'h4B; p[31:8] = d[31:8]; p[35:32] = onib(lane(d, 0));
         for (int j = 4; j < 8; j++) p[8+7*j +: 7] = narrow(lane(d, j));
      end else if (c == 8'h1F && lane(d, 4) == 8'hFB) begin
         p[7:0] = 8'h33; p[63:40] = d[63:40];
         for (int j = 0; j < 4; j++) p[8+7*j +: 7] = narrow(lane(d, j));
      end else if (c == 8'h1F && is_os(lane(d, 4))) begin
         p[7:0] = 8'h2D; p[63:40] = d[63:40]; p[39:36] = onib(lane(d, 4));
         for (int j = 0; j < 4; j++) p[8+7*j +: 7] = narrow(lane(d, j));
      end else if (c == (8'hFF << t) && lane(d, t) == 8'hFD) begin
         p[7:0] = tcodes[t];
         for (int j = 0; j < t; j++) p[8+8*j +: 8] = lane(d, j);
         for (int j = t + 1; j < 8; j++) p[8+7*j +: 7] = narrow(lane(d, j));
      end else begin
         p[7:0] = 8'h1E;
         for (int j = 0; j < 8; j++) p[8+7*j +: 7] = narrow(lane(d, j));
      end
      return {2'b01, p};
   endfunction

   task automatic check(input string req, input logic [63:0] ed,
                        input logic [7:0] ec, input logic ee);
      n_checks++;
      if (xg_data !== ed || xg_ctrl !== ec || decode_err !== ee) begin
         n_fails++;
         $display("FAIL %s: got data=%h ctrl=%h err=%b expected data=%h ctrl=%h err=%b",
                  req, xg_data, xg_ctrl, decode_err, ed, ec, ee);
      end
   endtask

   task automatic drive(input logic [1:0] s, input logic [63:0] p);
      @(negedge clk);
      rx_sync = s;
      rx_payload = p;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [65:0] blk;
      logic [63:0] p;

      // R11: reset word
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R11 reset", 64'h0707070707070707, 8'hFF, 1'b0);
      rst = 1'b0;

      // R1,R2,R4,R5,R6,R7,R12: round trip of every block kind
      for (int v = 0; v < NVEC; v++) begin
         blk = encode(VECS[v][63:0], VECS[v][71:64]);
         drive(blk[65:64], blk[63:0]);
         check($sformatf("R1/R2/R4/R5/R6/R7/R12 vector %0d", v),
               VECS[v][63:0], VECS[v][71:64], 1'b0);
      end

      // R10: output holds until the next edge
      @(negedge clk);
      rx_sync = 2'b10;
      rx_payload = 64'hCAFEF00D12345678;
      #1;
      check("R10 before edge", 64'h0606060607070707, 8'hFF, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R10 after edge", 64'hCAFEF00D12345678, 8'h00, 1'b0);

      // R8: bad headers
      drive(2'b00, 64'h1122334455667788);
      check("R8 header 00", {8{8'hFE}}, 8'hFF, 1'b1);
      drive(2'b11, 64'h0000000000000078);
      check("R8 header 11", {8{8'hFE}}, 8'hFF, 1'b1);

      // R9: unknown block type
      drive(2'b01, 64'h0000000000000000);
      check("R9 unknown type", {8{8'hFE}}, 8'hFF, 1'b1);

      // R3: one unmapped code in an all-control block
      p = '0; p[7:0] = 8'h1E; p[8+7*2 +: 7] = 7'h11;
      drive(2'b01, p);
      check("R3 bad code lane2", 64'h0707070707FE0707, 8'hFF, 1'b1);

      // R6: bad ordered-set code in lane 0
      p = {28'h0, 4'h5, 24'h332211, 8'h4B};
      drive(2'b01, p);
      check("R6 bad ocode", 64'h07070707332211FE, 8'hF1, 1'b1);

      // R7/R3: terminate lane 5 with a bad trailing code
      p = '0; p[7:0] = 8'hD2; p[47:8] = 40'hEEDDCCBBAA; p[8+7*6 +: 7] = 7'h7F;
      drive(2'b01, p);
      check("R7 term5 bad tail", 64'h07FEFDEEDDCCBBAA, 8'hE0, 1'b1);

      // R12: a clean block clears the flag again
      drive(2'b10, 64'h0F0E0D0C0B0A0908);
      check("R12 flag clears", 64'h0F0E0D0C0B0A0908, 8'h00, 1'b0);

      // R11: reset in mid-run
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R11 mid-run reset", 64'h0707070707070707, 8'hFF, 1'b0);
      rst = 1'b0;

      finish_run();
   end

endmodule